// File: doc/BRIEF.md
# A/D Conversion Timing Sequencer

This block produces the phase timing for a successive-approximation A/D converter that waits for a hardware trigger. It derives a conversion clock from the peripheral clock through a selectable, not necessarily power-of-two, divider. It times each conversion as a power-supply settling wait, a sampling phase and a bit-conversion phase. At the end of the last conversion clock it issues a one-cycle done pulse together with a strobe that tells the result register to capture. The comparator, the DAC and the result storage are outside this block.

Software arms the sequencer with `enable` and `start`. A pulse on `hwTrig` then launches a conversion. The settling wait is only inserted for the first conversion after a trigger. In sequential mode, later conversions go straight into sampling. The divider, voltage-mode and resolution settings are latched only while both `enable` and `start` are low.

Top module: `adc_seq_timer`

## Requirements
- R1: `divSel` codes 0 to 7 select a conversion-clock period of 64, 32, 16, 8, 6, 5, 4 and 2 peripheral clocks, in that order.
- R2: An accepted trigger starts a settling phase (`phStab` high) lasting 2 conversion clocks, and every busy period begins with it.
- R3: With `lvMode` at any code other than 2'b11, sampling lasts 7 conversion clocks and the conversion phase 12 at 10-bit resolution.
- R4: With `lvMode` = 2'b11, sampling lasts 5 conversion clocks and the conversion phase 12 at 10-bit resolution.
- R5: With `res8` = 1, the conversion phase is 2 conversion clocks shorter than at 10-bit resolution. The sampling phase does not change.
- R6: A single conversion keeps `busy` high for exactly ratio × (2 + sample + convert) peripheral clocks, for example 1344 at code 0 in the R3 mode. `done` and `capture` are high together for exactly one clock, which is the last busy cycle.
- R7: In one-shot mode (`seqMode` = 0), `busy` is low in the cycle after `done` and stays low until another trigger.
- R8: If `seqMode` and `start` are both high in the `done` cycle, the next cycle begins a sampling phase with no settling wait.
- R9: `divSel`, `lvMode` and `res8` are latched only in cycles where `enable` and `start` are both low. Changes at any other time have no effect.
- R10: A trigger is accepted only while the sequencer is not busy and `enable` and `start` are both high. A trigger while busy, including in the `done` cycle, is ignored.
- R11: When `enable` is low, `busy` and all phase outputs are low in the next cycle. A `done` that would fall in a cycle where `enable` is low is suppressed.
- R12: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter enable; when low, aborts any conversion |
| start | input | 1 | Arms trigger acceptance and sequential continuation |
| hwTrig | input | 1 | Hardware trigger |
| divSel | input | 3 | Conversion-clock divider code |
| lvMode | input | 2 | Voltage mode; 2'b11 selects the short-sampling mode |
| res8 | input | 1 | 1 selects 8-bit resolution |
| seqMode | input | 1 | 1 selects sequential conversion |
| phStab | output | 1 | Settling wait in progress |
| phSample | output | 1 | Sampling phase in progress |
| phConv | output | 1 | Bit-conversion phase in progress |
| busy | output | 1 | Any phase in progress |
| done | output | 1 | One-clock end-of-conversion pulse |
| capture | output | 1 | Result capture strobe, coincident with done |

## Verification
Two collisions fall on the final cycle of a conversion. A trigger can arrive in the same cycle as `done`, and `enable` can drop in that same cycle. The bench raises `hwTrig` exactly in the cycle where `done` is seen. It then requires that `busy` stays low afterwards and that no second `done` appears. In a separate run it counts to the last busy cycle and clears `enable` there. It then requires `done` and `capture` to go low in that cycle and `busy` to be low in the next.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_STAB,
    ST_SAMP,
    ST_CONV
  } seqState_t;

  typedef enum logic [1:0] {
    PH_STAB = 2'd0,
    PH_SAMP = 2'd1,
    PH_CONV = 2'd2
  } phaseSel_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic      cfgWe;    // latch divider / mode / resolution
    logic      preClr;   // hold prescaler at zero
    logic      cntClr;   // hold phase counter at zero
    phaseSel_t phaseSel; // which phase length applies
  } seqStrobe_t;

  // Divider ratio per select code (peripheral clocks per conversion clock)
  function automatic logic [6:0] divRatio(input logic [2:0] sel);
    logic [6:0] r;
    case (sel)
      3'd0:    r = 7'd64;
      3'd1:    r = 7'd32;
      3'd2:    r = 7'd16;
      3'd3:    r = 7'd8;
      3'd4:    r = 7'd6;
      3'd5:    r = 7'd5;
      3'd6:    r = 7'd4;
      default: r = 7'd2;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int PRE_W     = 7,
  parameter int CNT_W     = 5,
  parameter int STAB_CLKS = 2,
  parameter int LV1_SAMP  = 7,
  parameter int LV1_TOTAL = 19,
  parameter int LV2_SAMP  = 5,
  parameter int LV2_TOTAL = 17,
  parameter int SHORT8    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] divSel,
  input  logic [1:0] lvMode,
  input  logic       res8,
  input  seqStrobe_t strb,
  output logic       phaseEnd
);

  localparam int LV1_CONV = LV1_TOTAL - LV1_SAMP;
  localparam int LV2_CONV = LV2_TOTAL - LV2_SAMP;

  logic [2:0]       divQ;
  logic [1:0]       lvQ;
  logic             res8Q;
  logic [PRE_W-1:0] preQ;
  logic [PRE_W-1:0] ratio;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] convBase;
  logic             isLv2;
  logic             tick;

  // Configuration latch: only written while the converter is stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ  <= '0;
      lvQ   <= '0;
      res8Q <= 1'b0;
    end else if (strb.cfgWe) begin
      divQ  <= divSel;
      lvQ   <= lvMode;
      res8Q <= res8;
    end
  end

  assign ratio = PRE_W'(divRatio(divQ));
  assign isLv2 = (lvQ == 2'b11);
  assign tick  = (preQ == ratio - PRE_W'(1));

  // Prescaler producing one tick per conversion clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            preQ <= '0;
    else if (strb.preClr) preQ <= '0;
    else if (tick)        preQ <= '0;
    else                  preQ <= preQ + PRE_W'(1);
  end

  // Phase length selection
  always_comb begin
    convBase = isLv2 ? CNT_W'(LV2_CONV) : CNT_W'(LV1_CONV);
    case (strb.phaseSel)
      PH_STAB: limit = CNT_W'(STAB_CLKS);
      PH_SAMP: limit = isLv2 ? CNT_W'(LV2_SAMP) : CNT_W'(LV1_SAMP);
      default: limit = res8Q ? convBase - CNT_W'(SHORT8) : convBase;
    endcase
  end

  assign phaseEnd = tick && (cntQ == limit - CNT_W'(1));

  // Conversion-clock counter within the current phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (strb.cntClr) cntQ <= '0;
    else if (phaseEnd)    cntQ <= '0;
    else if (tick)        cntQ <= cntQ + CNT_W'(1);
  end

  AST_PRE_BELOW_RATIO: assert property (@(posedge clk) disable iff (!rstN)
    preQ < ratio); // R1

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntClr |-> cntQ < limit); // R5

endmodule

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       start,
  input  logic       hwTrig,
  input  logic       seqMode,
  input  logic       phaseEnd,
  output seqStrobe_t strb,
  output logic       phStab,
  output logic       phSample,
  output logic       phConv,
  output logic       busy,
  output logic       done,
  output logic       capture
);

  seqState_t stateQ, stateD;
  logic      armed;

  assign armed = enable && start;

  always_comb begin
    stateD = stateQ;
    if (!enable) begin
      stateD = ST_IDLE;
    end else begin
      case (stateQ)
        ST_IDLE, ST_WAIT: stateD = (armed && hwTrig) ? ST_STAB : ST_WAIT;
        ST_STAB:          if (phaseEnd) stateD = ST_SAMP;
        ST_SAMP:          if (phaseEnd) stateD = ST_CONV;
        ST_CONV:          if (phaseEnd) stateD = (seqMode && start) ? ST_SAMP : ST_WAIT;
        default:          stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // Strobes toward the datapath
  always_comb begin
    strb.cfgWe  = !enable && !start;
    strb.preClr = (stateQ == ST_IDLE) || (stateQ == ST_WAIT);
    strb.cntClr = strb.preClr;
    case (stateQ)
      ST_SAMP: strb.phaseSel = PH_SAMP;
      ST_CONV: strb.phaseSel = PH_CONV;
      default: strb.phaseSel = PH_STAB;
    endcase
  end

  assign phStab   = (stateQ == ST_STAB);
  assign phSample = (stateQ == ST_SAMP);
  assign phConv   = (stateQ == ST_CONV);
  assign busy     = phStab || phSample || phConv;
  assign done     = enable && phConv && phaseEnd;
  assign capture  = done;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_STAB_LEADS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> phStab); // R2

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busy); // R11

  AST_SEQ_SKIP_STAB: assert property (@(posedge clk) disable iff (!rstN)
    (done && seqMode && start) |=> phSample); // R8

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && enable) |=> busy); // R10

  AST_ONESHOT_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (done && !seqMode) |=> !busy); // R7

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int PRE_W     = 7,
  parameter int CNT_W     = 5,
  parameter int STAB_CLKS = 2,
  parameter int LV1_SAMP  = 7,
  parameter int LV1_TOTAL = 19,
  parameter int LV2_SAMP  = 5,
  parameter int LV2_TOTAL = 17,
  parameter int SHORT8    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       start,
  input  logic       hwTrig,
  input  logic [2:0] divSel,
  input  logic [1:0] lvMode,
  input  logic       res8,
  input  logic       seqMode,
  output logic       phStab,
  output logic       phSample,
  output logic       phConv,
  output logic       busy,
  output logic       done,
  output logic       capture
);

  seqStrobe_t strb;
  logic       phaseEnd;

  adc_seq_dp #(
    .PRE_W(PRE_W), .CNT_W(CNT_W), .STAB_CLKS(STAB_CLKS),
    .LV1_SAMP(LV1_SAMP), .LV1_TOTAL(LV1_TOTAL),
    .LV2_SAMP(LV2_SAMP), .LV2_TOTAL(LV2_TOTAL), .SHORT8(SHORT8)
  ) dp_i (
    .clk(clk), .rstN(rstN), .divSel(divSel), .lvMode(lvMode), .res8(res8),
    .strb(strb), .phaseEnd(phaseEnd)
  );

  adc_seq_ctl ctl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .start(start), .hwTrig(hwTrig),
    .seqMode(seqMode), .phaseEnd(phaseEnd), .strb(strb),
    .phStab(phStab), .phSample(phSample), .phConv(phConv),
    .busy(busy), .done(done), .capture(capture)
  );

endmodule

// File: tb/adc_seq_timer_tb_top.sv
`timescale 1ns/1ps
module adc_seq_timer_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, start = 1'b0, hwTrig = 1'b0, res8 = 1'b0, seqMode = 1'b0;
  logic [2:0] divSel = '0;
  logic [1:0] lvMode = '0;
  logic phStab, phSample, phConv, busy, done, capture;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_seq_timer dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .start(start), .hwTrig(hwTrig),
    .divSel(divSel), .lvMode(lvMode), .res8(res8), .seqMode(seqMode),
    .phStab(phStab), .phSample(phSample), .phConv(phConv),
    .busy(busy), .done(done), .capture(capture)
  );

  function automatic int ratioOf(input int d);
    case (d)
      0: return 64; 1: return 32; 2: return 16; 3: return 8;
      4: return 6;  5: return 5;  6: return 4;  default: return 2;
    endcase
  endfunction
  function automatic int sampOf(input int l);
    return (l == 3) ? 5 : 7;
  endfunction
  function automatic int convOf(input int l, input int r);
    return ((l == 3) ? 12 : 12) - (r != 0 ? 2 : 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic configure(input int d, input int l, input int r);
    enable = 0; start = 0; seqMode = 0; hwTrig = 0;
    divSel = 3'(d); lvMode = 2'(l); res8 = 1'(r);
    step(); step();
  endtask

  task automatic trigger();
    hwTrig = 1; step(); hwTrig = 0;
  endtask

  // Trigger, then count cycles per phase until busy falls
  task automatic measure(input int trigAt, input bit trigOnDone,
                         output int st, output int sp, output int cv, output int tot,
                         output int dn, output int di, output int cm);
    st = 0; sp = 0; cv = 0; tot = 0; dn = 0; di = -1; cm = 0;
    trigger();
    while (busy && tot < 6000) begin
      if (phStab) st++;
      if (phSample) sp++;
      if (phConv) cv++;
      if (done) begin dn++; di = tot; end
      if (capture != done) cm++;
      hwTrig = (tot == trigAt) || (trigOnDone && done);
      tot++;
      step();
    end
    hwTrig = 0;
  endtask

  task automatic checkRun(input int d, input int l, input int r, input int trigAt, input bit tod);
    int st, sp, cv, tot, dn, di, cm, q, s, c;
    q = ratioOf(d); s = sampOf(l); c = convOf(l, r);
    measure(trigAt, tod, st, sp, cv, tot, dn, di, cm);
    chk(st == 2 * q, "R2 stab cycles", st, 2 * q);
    chk(sp == s * q, (l == 3) ? "R4 sample cycles" : "R3 sample cycles", sp, s * q);
    chk(cv == c * q, r ? "R5 conv cycles" : "R3 conv cycles", cv, c * q);
    chk(tot == q * (2 + s + c), "R6 R1 total busy", tot, q * (2 + s + c));
    chk(dn == 1, "R6 done count", dn, 1);
    chk(di == tot - 1, "R6 done position", di, tot - 1);
    chk(cm == 0, "R6 capture mismatch", cm, 0);
    for (int k = 0; k < 4; k++) begin
      chk(!busy && !done, "R7 R10 idle after one-shot", busy, 0);
      step();
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end

  initial begin : main
    int seedInit;
    seedInit = $urandom(32'd4242);
    step(); step();
    // R12 reset state
    chk({phStab, phSample, phConv, busy, done, capture} == 6'b0, "R12 reset outputs",
        {phStab, phSample, phConv, busy, done, capture}, 0);
    rstN = 1; step();
    chk(!busy && !done, "R12 after reset", busy, 0);

    // R1 every divider code, mode 1 at 10 bits (code 0 gives 1344)
    for (int d = 0; d < 8; d++) begin
      configure(d, 2, 0); enable = 1; start = 1; step();
      checkRun(d, 2, 0, -1, 0);
    end

    // R4 R5 directed
    configure(4, 3, 0); enable = 1; start = 1; step(); checkRun(4, 3, 0, -1, 0);
    configure(5, 3, 1); enable = 1; start = 1; step(); checkRun(5, 3, 1, -1, 0);
    configure(6, 0, 1); enable = 1; start = 1; step(); checkRun(6, 0, 1, -1, 0);

    // R10 trigger mid-conversion and trigger in the done cycle
    configure(6, 3, 0); enable = 1; start = 1; step(); checkRun(6, 3, 0, 9, 1);

    // R10 trigger with start low is ignored
    configure(7, 0, 0); enable = 1; start = 0; step();
    trigger();
    for (int k = 0; k < 3; k++) begin
      chk(!busy, "R10 no start no conversion", busy, 0); step();
    end

    // R9 config changes while enabled are ignored
    configure(7, 3, 1);
    enable = 1; start = 0; step();
    divSel = 3'd0; lvMode = 2'd0; res8 = 0; step(); step();
    start = 1; step();
    checkRun(7, 3, 1, -1, 0);

    // R8 sequential: second conversion skips settling
    begin
      int st, tot, dn, afterSample;
      configure(7, 3, 0); seqMode = 1; enable = 1; start = 1; step();
      st = 0; tot = 0; dn = 0; afterSample = 0;
      trigger();
      while (busy && tot < 500) begin
        if (phStab) st++;
        if (done) dn++;
        tot++;
        step();
        if (dn == 1 && seqMode) begin
          afterSample = phSample;
          seqMode = 0;
        end
      end
      chk(afterSample == 1, "R8 sample follows done", afterSample, 1);
      chk(st == 4, "R8 single settling", st, 4);
      chk(dn == 2, "R8 done count", dn, 2);
      chk(tot == 72, "R8 total busy", tot, 72);
    end

    // R11 abort mid-conversion
    configure(6, 2, 0); enable = 1; start = 1; step();
    trigger();
    repeat (10) step();
    chk(busy, "R11 busy before abort", busy, 1);
    enable = 0; step();
    chk({phStab, phSample, phConv, busy} == 4'b0, "R11 abort within one clock",
        {phStab, phSample, phConv, busy}, 0);

    // R11 abort collides with the done cycle
    configure(7, 3, 1); enable = 1; start = 1; step();
    trigger();
    repeat (33) step();
    chk(done, "R6 done at last cycle", done, 1);
    enable = 0; #1;
    chk(!done && !capture, "R11 done suppressed", done, 0);
    step();
    chk(!busy, "R11 idle after collision", busy, 1'b0);

    // Random runs
    for (int i = 0; i < 30; i++) begin
      int d, l, r, ta;
      d = $urandom % 8; l = $urandom % 4; r = $urandom % 2;
      ta = ($urandom % 3 == 0) ? int'($urandom % 20) : -1;
      configure(d, l, r); enable = 1; start = 1; step();
      checkRun(d, l, r, ta, 1'($urandom % 2));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

endmodule